// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block sits beside a timer counter. It chooses which of eight trigger lines drives the counter and turns that line into the counter's control strobes, according to a 3-bit slave-mode field. The controller can restart the counter, gate its count clock, start it once, clock it from edges, or decode a two-phase quadrature signal into counts and a direction.

Both select fields are plain inputs. A rising edge means the selected line is high in the current cycle and was low in the cycle before. The controller keeps a registered copy of the line for this test. Every output is registered, so a response appears on the cycle after the input that caused it. The counter itself and any input filtering are outside this block.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: `trig_sel_i` picks the trigger. Codes 0 to 3 select `itrig_i[0]` to `itrig_i[3]`, 4 selects `ti1_edge_i`, 5 selects `ti1_filt_i`, 6 selects `ti2_filt_i` and 7 selects `ext_trig_i`. The unselected lines have no effect on any trigger-based output.
- R2: A rising edge is the selected trigger high on the current clock edge and low on the previous one. Each rising edge gives a single-cycle strobe on the next cycle.
- R3: Slave mode 0 (disabled) holds `cnt_step_o` high on every cycle and keeps `cen_set_o` and `cnt_rst_upd_o` low.
- R4: Slave mode 4 (reset) pulses `cnt_rst_upd_o` for one cycle after each rising trigger edge.
- R5: Slave mode 5 (gated) makes `cnt_step_o` follow the level of the selected trigger one cycle later, with no reset strobe.
- R6: Slave mode 6 (start) pulses `cen_set_o` for one cycle after each rising trigger edge. Falling edges and steady levels give nothing.
- R7: Slave mode 7 (edge clock) pulses `cnt_step_o` for one cycle after each rising trigger edge.
- R8: Slave mode 1 steps on every change of `ti1_filt_i` (A) while `ti2_filt_i` (B) stays the same. `cnt_dir_o` is 1 (up) when the new A differs from B and 0 otherwise, so the count goes up when A leads B.
- R9: Slave mode 2 steps on every change of B while A stays the same. The direction is up when the new B equals A.
- R10: Slave mode 3 steps on a change of either input, using the rule of R8 or R9. A cycle in which A and B both change gives no step.
- R11: Reset drives all strobes low and `cnt_dir_o` to 1. `cnt_dir_o` changes only on a quadrature step and otherwise holds.
- R12: `cen_set_o` is high only in mode 6 and `cnt_rst_upd_o` only in mode 4. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| itrig_i | input | 4 | Internal trigger lines |
| ti1_edge_i | input | 1 | Edge-detected first timer input |
| ti1_filt_i | input | 1 | Filtered, polarity-adjusted first input (quadrature A) |
| ti2_filt_i | input | 1 | Filtered, polarity-adjusted second input (quadrature B) |
| ext_trig_i | input | 1 | External trigger |
| trig_sel_i | input | 3 | Trigger source select |
| slave_mode_i | input | 3 | Slave mode select |
| cen_set_o | output | 1 | Counter-enable set strobe |
| cnt_rst_upd_o | output | 1 | Counter reinitialise and register-update strobe |
| cnt_step_o | output | 1 | Count-clock enable |
| cnt_dir_o | output | 1 | Count direction, 1 = up |

## Verification
Two cases are hard to reach from the ports. The first is when both quadrature inputs change in the same cycle. The second is when the trigger history holds a different source because the select changed. The bench sweeps every trigger source under every trigger-based mode and drives each unselected line to the opposite level of the selected one. A wrong mux choice therefore shows up as a missing or extra strobe. For each encoder mode it then plays forward and reverse Gray sequences, single-input jitter and simultaneous two-input changes. The history carries over across mode switches, and the bench's own model tracks the previous sampled levels to predict these carried-over edges.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    SM_OFF    = 3'd0,
    SM_ENC_A  = 3'd1,
    SM_ENC_B  = 3'd2,
    SM_ENC_AB = 3'd3,
    SM_RESET  = 3'd4,
    SM_GATED  = 3'd5,
    SM_START  = 3'd6,
    SM_EXTCLK = 3'd7
  } slave_mode_e;
endpackage

// File: rtl/tmr_trig_mux.sv
module tmr_trig_mux #(
  parameter int N_ITRIG = 4,
  localparam int N_SRC  = N_ITRIG + 4,
  localparam int SEL_W  = $clog2(N_SRC)
) (
  input  logic [N_ITRIG-1:0] itrig_i,
  input  logic               ti1_edge_i,
  input  logic               ti1_filt_i,
  input  logic               ti2_filt_i,
  input  logic               ext_trig_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               trig_o
);
  logic [N_SRC-1:0] src;

  assign src    = {ext_trig_i, ti2_filt_i, ti1_filt_i, ti1_edge_i, itrig_i};
  assign trig_o = src[sel_i];
endmodule

// File: rtl/tmr_hist_reg.sv
module tmr_hist_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] prev_o
);
  always_ff @(posedge clk) begin
    if (rst) prev_o <= '0;
    else     prev_o <= lvl_i;
  end
endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec
  import tmr_slave_pkg::*;
(
  input  slave_mode_e mode_i,
  input  logic [1:0]  cur_i,   // {B, A}
  input  logic [1:0]  prev_i,
  output logic        step_o,
  output logic        up_o
);
  logic [1:0] chg;
  logic       a_only, b_only, up_a, up_b;

  assign chg    = cur_i ^ prev_i;
  assign a_only = chg[0] & ~chg[1];
  assign b_only = chg[1] & ~chg[0];
  assign up_a   = cur_i[0] ^ cur_i[1];
  assign up_b   = ~(cur_i[0] ^ cur_i[1]);

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    unique case (mode_i)
      SM_ENC_A: begin
        step_o = a_only;
        up_o   = up_a;
      end
      SM_ENC_B: begin
        step_o = b_only;
        up_o   = up_b;
      end
      SM_ENC_AB: begin
        step_o = a_only | b_only;
        up_o   = a_only ? up_a : up_b;
      end
      default: begin
        step_o = 1'b0;
        up_o   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
  import tmr_slave_pkg::*;
#(
  parameter int N_ITRIG = 4,
  localparam int SEL_W  = $clog2(N_ITRIG + 4)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_ITRIG-1:0] itrig_i,
  input  logic               ti1_edge_i,
  input  logic               ti1_filt_i,
  input  logic               ti2_filt_i,
  input  logic               ext_trig_i,
  input  logic [SEL_W-1:0]   trig_sel_i,
  input  logic [MODE_W-1:0]  slave_mode_i,
  output logic               cen_set_o,
  output logic               cnt_rst_upd_o,
  output logic               cnt_step_o,
  output logic               cnt_dir_o
);
  slave_mode_e mode;
  logic        trig, trig_prev, trig_rise;
  logic [1:0]  quad_cur, quad_prev;
  logic        enc_step, enc_up;

  assign mode     = slave_mode_e'(slave_mode_i);
  assign quad_cur = {ti2_filt_i, ti1_filt_i};

  tmr_trig_mux #(.N_ITRIG(N_ITRIG)) mux_i (
    .itrig_i    (itrig_i),
    .ti1_edge_i (ti1_edge_i),
    .ti1_filt_i (ti1_filt_i),
    .ti2_filt_i (ti2_filt_i),
    .ext_trig_i (ext_trig_i),
    .sel_i      (trig_sel_i),
    .trig_o     (trig)
  );

  tmr_hist_reg #(.W(1)) trig_hist_i (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (trig),
    .prev_o (trig_prev)
  );

  tmr_hist_reg #(.W(2)) quad_hist_i (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (quad_cur),
    .prev_o (quad_prev)
  );

  assign trig_rise = trig & ~trig_prev;

  tmr_quad_dec dec_i (
    .mode_i (mode),
    .cur_i  (quad_cur),
    .prev_i (quad_prev),
    .step_o (enc_step),
    .up_o   (enc_up)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cen_set_o     <= 1'b0;
      cnt_rst_upd_o <= 1'b0;
      cnt_step_o    <= 1'b0;
      cnt_dir_o     <= 1'b1;
    end else begin
      cen_set_o     <= (mode == SM_START) & trig_rise;
      cnt_rst_upd_o <= (mode == SM_RESET) & trig_rise;
      unique case (mode)
        SM_OFF:                        cnt_step_o <= 1'b1;
        SM_GATED:                      cnt_step_o <= trig;
        SM_EXTCLK:                     cnt_step_o <= trig_rise;
        SM_ENC_A, SM_ENC_B, SM_ENC_AB: cnt_step_o <= enc_step;
        default:                       cnt_step_o <= 1'b0;
      endcase
      if (enc_step) cnt_dir_o <= enc_up;
    end
  end
endmodule

// File: rtl/tmr_slave_ctrl_chk.sv
module tmr_slave_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] slave_mode_i,
  input logic [2:0] trig_sel_i,
  input logic       ext_trig_i,
  input logic       ti1_filt_i,
  input logic       ti2_filt_i,
  input logic       cen_set_o,
  input logic       cnt_rst_upd_o,
  input logic       cnt_step_o,
  input logic       cnt_dir_o
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_START_ONLY_IN_MODE6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cen_set_o) |-> $past(slave_mode_i) == 3'd6); // R6
  AST_RESET_ONLY_IN_MODE4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cnt_rst_upd_o) |-> $past(slave_mode_i) == 3'd4); // R4
  AST_OFF_ALWAYS_STEPS: assert property (@(posedge clk) disable iff (rst)
    (slave_mode_i == 3'd0) |=> cnt_step_o); // R3
  AST_GATED_FOLLOWS_EXT: assert property (@(posedge clk) disable iff (rst)
    (slave_mode_i == 3'd5 && trig_sel_i == 3'd7) |=> (cnt_step_o == $past(ext_trig_i))); // R5
  AST_BOTH_EDGES_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && slave_mode_i == 3'd3 && $changed(ti1_filt_i) && $changed(ti2_filt_i))
      |=> !cnt_step_o); // R10
  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !cnt_step_o) |-> $stable(cnt_dir_o)); // R11
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cen_set_o, cnt_rst_upd_o})); // R12
endmodule

bind tmr_slave_ctrl tmr_slave_ctrl_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .slave_mode_i  (slave_mode_i),
  .trig_sel_i    (trig_sel_i),
  .ext_trig_i    (ext_trig_i),
  .ti1_filt_i    (ti1_filt_i),
  .ti2_filt_i    (ti2_filt_i),
  .cen_set_o     (cen_set_o),
  .cnt_rst_upd_o (cnt_rst_upd_o),
  .cnt_step_o    (cnt_step_o),
  .cnt_dir_o     (cnt_dir_o)
);

// File: tb/tmr_slave_ctrl_tb_top.sv
module tmr_slave_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] itrig;
  logic       ti1_edge, ti1_filt, ti2_filt, ext_trig;
  logic [2:0] trig_sel, slave_mode;
  logic       cen_set, cnt_rst_upd, cnt_step, cnt_dir;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic m_trig_prev, m_a_prev, m_b_prev, m_dir;

  always #5 clk = ~clk;

  tmr_slave_ctrl dut_i (
    .clk           (clk),
    .rst           (rst),
    .itrig_i       (itrig),
    .ti1_edge_i    (ti1_edge),
    .ti1_filt_i    (ti1_filt),
    .ti2_filt_i    (ti2_filt),
    .ext_trig_i    (ext_trig),
    .trig_sel_i    (trig_sel),
    .slave_mode_i  (slave_mode),
    .cen_set_o     (cen_set),
    .cnt_rst_upd_o (cnt_rst_upd),
    .cnt_step_o    (cnt_step),
    .cnt_dir_o     (cnt_dir)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b (mode=%0d sel=%0d t=%0t)",
               req, what, act, exp, slave_mode, trig_sel, $time);
    end
  endtask

  function automatic string step_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R8";
      3'd2: return "R9";
      3'd3: return "R10";
      3'd5: return "R1,R5";
      3'd7: return "R1,R2,R7";
      default: return "R12";
    endcase
  endfunction

  // src bit order = trigger-select code: [3:0] itrig, 4 ti1_edge, 5 ti1_filt (A), 6 ti2_filt (B), 7 ext
  task automatic cycle(input logic [7:0] src, input logic [2:0] sel, input logic [2:0] mode);
    logic cur, rise, a, b, da, db, e_step, e_up, enc;
    @(negedge clk);
    itrig = src[3:0]; ti1_edge = src[4]; ti1_filt = src[5];
    ti2_filt = src[6]; ext_trig = src[7];
    trig_sel = sel; slave_mode = mode;
    cur  = src[sel];
    rise = cur & ~m_trig_prev;
    a = src[5]; b = src[6];
    da = a ^ m_a_prev; db = b ^ m_b_prev;
    enc = 1'b0; e_up = 1'b1;
    case (mode)
      3'd1: begin enc = da & ~db; e_up = a ^ b; end
      3'd2: begin enc = db & ~da; e_up = ~(a ^ b); end
      3'd3: begin
        enc = (da & ~db) | (db & ~da);
        e_up = (da & ~db) ? (a ^ b) : ~(a ^ b);
      end
      default: enc = 1'b0;
    endcase
    case (mode)
      3'd0: e_step = 1'b1;
      3'd5: e_step = cur;
      3'd7: e_step = rise;
      3'd1, 3'd2, 3'd3: e_step = enc;
      default: e_step = 1'b0;
    endcase
    if (enc) m_dir = e_up;
    m_trig_prev = cur; m_a_prev = a; m_b_prev = b;
    @(posedge clk);
    #1;
    chk("R2,R6,R12", "cen_set", cen_set, (mode == 3'd6) & rise);
    chk("R2,R4,R12", "cnt_rst_upd", cnt_rst_upd, (mode == 3'd4) & rise);
    chk(step_tag(mode), "cnt_step", cnt_step, e_step);
    chk((mode inside {3'd1, 3'd2, 3'd3}) ? "R8,R9,R10,R11" : "R11", "cnt_dir", cnt_dir, m_dir);
  endtask

  localparam logic [11:0] TRIG_PAT = 12'b0111_0010_1100;
  // {B,A} sequence: forward Gray, reverse Gray, A jitter, B jitter, double changes
  localparam logic [1:0] QUAD_SEQ [20] = '{
    2'b00, 2'b01, 2'b11, 2'b10, 2'b00, 2'b01,
    2'b00, 2'b10, 2'b11, 2'b01, 2'b00,
    2'b01, 2'b00, 2'b01,
    2'b11, 2'b01, 2'b10, 2'b01, 2'b10, 2'b00
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] modes [5] = '{3'd0, 3'd4, 3'd5, 3'd6, 3'd7};
    rst = 1'b1; itrig = '0; ti1_edge = 1'b0; ti1_filt = 1'b0; ti2_filt = 1'b0;
    ext_trig = 1'b0; trig_sel = '0; slave_mode = '0;
    m_trig_prev = 1'b0; m_a_prev = 1'b0; m_b_prev = 1'b0; m_dir = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11", "reset cen_set", cen_set, 1'b0);
    chk("R11", "reset cnt_rst_upd", cnt_rst_upd, 1'b0);
    chk("R11", "reset cnt_step", cnt_step, 1'b0);
    chk("R11", "reset cnt_dir", cnt_dir, 1'b1);
    @(negedge clk);
    rst = 1'b0;

    // R1..R7, R12: every source under every trigger-based mode, others opposite
    for (int mi = 0; mi < 5; mi++) begin
      for (int s = 0; s < 8; s++) begin
        for (int t = 0; t < 12; t++) begin
          logic [7:0] onehot;
          onehot = 8'b1 << s;
          cycle(TRIG_PAT[t] ? onehot : ~onehot, 3'(s), modes[mi]);
        end
      end
    end

    // R8, R9, R10, R11: quadrature modes
    for (int m = 1; m <= 3; m++) begin
      for (int k = 0; k < 20; k++) begin
        cycle({1'b0, QUAD_SEQ[k][1], QUAD_SEQ[k][0], 5'b0}, 3'd0, 3'(m));
      end
    end

    // R11: direction holds when leaving encoder modes and triggers toggle
    for (int k = 0; k < 6; k++) cycle({1'b0, 1'(k[0]), 1'(k[1]), 5'b0}, 3'd6, 3'd4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule